// File: doc/BRIEF.md
# DRAM Training Command Sequencer

This block runs a short, programmable list of DRAM commands during memory training. It has four command slots. Each slot sets the active-low row-strobe, column-strobe and write-enable levels, the clock-enable and termination levels per rank, a chip-select control word with an optional rank-masking mode, and a data direction tag. Each slot also sets how many times its command repeats, how many quiet cycles separate the repeats, and how many quiet cycles follow its last repeat.

Software sets the index of the last slot to run and a wait that follows each full pass. Writing a non-zero iteration count starts the engine. The engine walks the slots in order and counts the passes down until none remain. A count of all ones repeats without end until software writes zero. An error input from the data comparator can halt the run and raise a sticky trigger. In every cycle that does not issue a command, the pins carry a deselect.

Top module: `dram_train_sequencer`

## Requirements
- R1: While idle, writing a non-zero iteration count (`iterWrEn` with `iterWrData` != 0) starts a run. The first command, from slot 0, appears in the cycle after the write.
- R2: Slots run in order from 0 up to `lastSlot`. Each slot issues its command `reps`+1 times, so a repetition count of 0 issues it exactly once.
- R3: Between two repeats of the same slot there are `gap` deselect cycles. After the last repeat of a slot there are `idle` deselect cycles.
- R4: After every full pass except the final one, the engine inserts `postWait` deselect cycles before slot 0 issues again.
- R5: The iteration count drops by one after each full pass and is visible on `iterLeft`. When it reaches zero, the engine returns to idle in the next cycle with DONE set and `iterLeft` = 0.
- R6: A count of 8'hFF is never decremented. Writing zero while busy aborts the run: the engine is idle in the next cycle and DONE is not set.
- R7: In an issue cycle, `cmdValid` = 1. `rasN`, `casN` and `weN` come from slot bits [0], [1] and [2] of its 3-bit command field. `dataDir` is the slot's 2-bit direction: 0 none, 1 read, 2 write, 3 read and write.
- R8: In an issue cycle with the slot's chip-select mode at 0, `csN` equals the slot's control bits. With mode 1, the bit of the slot's rank select is forced low and the other bits keep the control value.
- R9: In every cycle that is not an issue cycle, `cmdValid` = 0, `csN` is all ones, `rasN`/`casN`/`weN` are 1 and `dataDir` = 0.
- R10: With `stopOnErr` = 1, `errIn` during a run sends the engine to idle in the next cycle with ERROR set and `iterLeft` = 0. With `stopOnErr` = 0, `errIn` changes neither the command stream nor the status.
- R11: With `trigEn` = 1, the first `errIn` during a run sets `trigOut`. It stays set until the next start clears it, and it stays low while `trigEn` = 0.
- R12: `status` bit 0 is IDLE, bit 1 is BUSY, bit 2 is DONE and bit 3 is ERROR. Exactly one of IDLE and BUSY is set. A start clears DONE and ERROR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iterWrEn | input | 1 | Write strobe for the iteration count |
| iterWrData | input | 8 | Iteration count value (FF = endless, 0 = abort) |
| lastSlot | input | 2 | Index of the last slot in a pass |
| postWait | input | 9 | Deselect cycles after each pass but the last |
| stopOnErr | input | 1 | Halt the run on an error |
| trigEn | input | 1 | Enable the error trigger output |
| errIn | input | 1 | Error indication from the data comparator |
| slotCmd | input | 12 | Per slot {weN,casN,rasN}, slot n at bits [3n+2:3n] |
| slotCke | input | 16 | Per slot clock enable per rank, 4 bits each |
| slotOdt | input | 16 | Per slot termination per rank, 4 bits each |
| slotCsCtl | input | 16 | Per slot chip-select control, 4 bits each |
| slotCsMode | input | 4 | Per slot chip-select masking mode |
| slotRank | input | 8 | Per slot rank select, 2 bits each |
| slotDir | input | 8 | Per slot data direction, 2 bits each |
| slotReps | input | 36 | Per slot repetition count, 9 bits each |
| slotGap | input | 20 | Per slot gap between repeats, 5 bits each |
| slotIdle | input | 36 | Per slot deselect cycles after the slot, 9 bits each |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| csN | output | 4 | Chip selects, active low |
| cke | output | 4 | Clock enables |
| odt | output | 4 | Termination enables |
| dataDir | output | 2 | Data direction of the current command |
| cmdValid | output | 1 | High in issue cycles |
| status | output | 4 | {ERROR, DONE, BUSY, IDLE} |
| iterLeft | output | 8 | Remaining iteration count |
| trigOut | output | 1 | Sticky trigger on the first error |

## Verification
The bench targets the places where nested counters usually slip by one. A repetition count of zero must still issue once. A gap must not follow the final repeat. The pass wait must not follow the final pass. A design that gets any of these wrong shifts every later command in the cycle-exact trace that the bench compares. Rank masking is checked in both modes: a wrong decode selects the wrong rank or none. The bench also checks that an endless count never decrements and that a zero write aborts at once without DONE. A missing decrement guard would end the run after 255 passes. Errors are checked both halting and ignored, so a design that ignores `stopOnErr` shows a truncated trace or a missing ERROR bit. The sticky trigger is checked to see that it is cleared only by a new start.

// File: rtl/train_seq_pkg.sv
package train_seq_pkg;
  localparam int SLOT_W    = 2;
  localparam int NUM_SLOTS = 1 << SLOT_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_GAP,
    ST_SLOTIDLE,
    ST_ITERWAIT
  } seqState_t;

  // strobes from the controller to the pin datapath
  typedef struct packed {
    logic              issue;
    logic              busy;
    logic [SLOT_W-1:0] slot;
  } seqStrobe_t;
endpackage

// File: rtl/train_seq_ctrl.sv
module train_seq_ctrl
  import train_seq_pkg::*;
#(
  parameter int REP_W  = 9,
  parameter int GAP_W  = 5,
  parameter int IDLE_W = 9,
  parameter int WAIT_W = 9,
  parameter int ITER_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        iterWrEn,
  input  logic [ITER_W-1:0]           iterWrData,
  input  logic [SLOT_W-1:0]           lastSlot,
  input  logic [WAIT_W-1:0]           postWait,
  input  logic                        stopOnErr,
  input  logic                        trigEn,
  input  logic                        errIn,
  input  logic [NUM_SLOTS*REP_W-1:0]  slotReps,
  input  logic [NUM_SLOTS*GAP_W-1:0]  slotGap,
  input  logic [NUM_SLOTS*IDLE_W-1:0] slotIdle,
  output seqStrobe_t                  strobe,
  output logic [ITER_W-1:0]           iterLeft,
  output logic                        doneFlag,
  output logic                        errFlag,
  output logic                        trigOut
);
  localparam int W1    = (REP_W > GAP_W) ? REP_W : GAP_W;
  localparam int W2    = (IDLE_W > WAIT_W) ? IDLE_W : WAIT_W;
  localparam int CNT_W = (W1 > W2) ? W1 : W2;
  localparam logic [ITER_W-1:0] ITER_INF = '1;

  seqState_t         state;
  logic [SLOT_W-1:0] slot;
  logic [REP_W-1:0]  repCnt;
  logic [CNT_W-1:0]  waitCnt;
  logic [ITER_W-1:0] iterCnt;

  logic [REP_W-1:0]  curReps;
  logic [GAP_W-1:0]  curGap;
  logic [IDLE_W-1:0] curIdle;
  logic              busy, startReq, abortReq, haltReq, wrBusy;
  logic              lastOfSlot, advanceNow;
  logic [ITER_W-1:0] iterAfter;

  always_comb begin
    curReps    = slotReps[slot*REP_W +: REP_W];
    curGap     = slotGap[slot*GAP_W +: GAP_W];
    curIdle    = slotIdle[slot*IDLE_W +: IDLE_W];
    busy       = (state != ST_IDLE);
    startReq   = !busy && iterWrEn && (iterWrData != '0);
    abortReq   = busy && iterWrEn && (iterWrData == '0);
    haltReq    = busy && errIn && stopOnErr;
    wrBusy     = busy && iterWrEn;
    lastOfSlot = (repCnt == curReps);
    advanceNow = ((state == ST_ISSUE) && lastOfSlot && (curIdle == '0)) ||
                 ((state == ST_SLOTIDLE) && (waitCnt == CNT_W'(1)));
    iterAfter  = (iterCnt == ITER_INF) ? iterCnt : iterCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      slot     <= '0;
      repCnt   <= '0;
      waitCnt  <= '0;
      iterCnt  <= '0;
      doneFlag <= 1'b0;
      errFlag  <= 1'b0;
      trigOut  <= 1'b0;
    end else begin
      if (busy && errIn && trigEn) trigOut <= 1'b1;
      if (startReq) begin
        state    <= ST_ISSUE;
        slot     <= '0;
        repCnt   <= '0;
        iterCnt  <= iterWrData;
        doneFlag <= 1'b0;
        errFlag  <= 1'b0;
        trigOut  <= 1'b0;
      end else if (abortReq) begin
        state   <= ST_IDLE;
        iterCnt <= '0;
      end else if (haltReq) begin
        state   <= ST_IDLE;
        iterCnt <= '0;
        errFlag <= 1'b1;
      end else begin
        if (wrBusy) iterCnt <= iterWrData;
        case (state)
          ST_ISSUE: begin
            if (!lastOfSlot) begin
              repCnt <= repCnt + 1'b1;
              if (curGap != '0) begin
                state   <= ST_GAP;
                waitCnt <= CNT_W'(curGap);
              end
            end else if (curIdle != '0) begin
              state   <= ST_SLOTIDLE;
              waitCnt <= CNT_W'(curIdle);
            end
          end
          ST_GAP, ST_ITERWAIT: begin
            if (waitCnt == CNT_W'(1)) state <= ST_ISSUE;
            else waitCnt <= waitCnt - 1'b1;
          end
          ST_SLOTIDLE: begin
            if (waitCnt != CNT_W'(1)) waitCnt <= waitCnt - 1'b1;
          end
          default: ;
        endcase
        if (advanceNow) begin
          repCnt <= '0;
          if (slot != lastSlot) begin
            slot  <= slot + 1'b1;
            state <= ST_ISSUE;
          end else begin
            slot <= '0;
            if (!wrBusy) iterCnt <= iterAfter;
            if (iterAfter == '0 && !wrBusy) begin
              state    <= ST_IDLE;
              doneFlag <= 1'b1;
            end else if (postWait != '0) begin
              state   <= ST_ITERWAIT;
              waitCnt <= CNT_W'(postWait);
            end else begin
              state <= ST_ISSUE;
            end
          end
        end
      end
    end
  end

  assign strobe.issue = (state == ST_ISSUE);
  assign strobe.busy  = busy;
  assign strobe.slot  = slot;
  assign iterLeft     = iterCnt;
endmodule

// File: rtl/train_seq_datapath.sv
module train_seq_datapath
  import train_seq_pkg::*;
#(
  parameter int RANKS = 4,
  parameter int DIR_W = 2
) (
  input  seqStrobe_t                          strobe,
  input  logic [NUM_SLOTS*3-1:0]              slotCmd,
  input  logic [NUM_SLOTS*RANKS-1:0]          slotCke,
  input  logic [NUM_SLOTS*RANKS-1:0]          slotOdt,
  input  logic [NUM_SLOTS*RANKS-1:0]          slotCsCtl,
  input  logic [NUM_SLOTS-1:0]                slotCsMode,
  input  logic [NUM_SLOTS*$clog2(RANKS)-1:0]  slotRank,
  input  logic [NUM_SLOTS*DIR_W-1:0]          slotDir,
  output logic                                rasN,
  output logic                                casN,
  output logic                                weN,
  output logic [RANKS-1:0]                    csN,
  output logic [RANKS-1:0]                    cke,
  output logic [RANKS-1:0]                    odt,
  output logic [DIR_W-1:0]                    dataDir,
  output logic                                cmdValid
);
  localparam int RSEL_W = $clog2(RANKS);

  logic [2:0]        curCmd;
  logic [RANKS-1:0]  curCtl, rankHot, csIssue;
  logic [RSEL_W-1:0] curRank;

  assign curCmd  = slotCmd[strobe.slot*3 +: 3];
  assign curCtl  = slotCsCtl[strobe.slot*RANKS +: RANKS];
  assign curRank = slotRank[strobe.slot*RSEL_W +: RSEL_W];

  for (genvar g = 0; g < RANKS; g++) begin : g_rank
    assign rankHot[g] = (curRank == RSEL_W'(g));
  end

  assign csIssue = slotCsMode[strobe.slot] ? (curCtl & ~rankHot) : curCtl;

  always_comb begin
    cmdValid = strobe.issue;
    rasN     = strobe.issue ? curCmd[0] : 1'b1;
    casN     = strobe.issue ? curCmd[1] : 1'b1;
    weN      = strobe.issue ? curCmd[2] : 1'b1;
    csN      = strobe.issue ? csIssue : '1;
    dataDir  = strobe.issue ? slotDir[strobe.slot*DIR_W +: DIR_W] : '0;
    cke      = strobe.busy ? slotCke[strobe.slot*RANKS +: RANKS] : '1;
    odt      = strobe.busy ? slotOdt[strobe.slot*RANKS +: RANKS] : '0;
  end
endmodule

// File: rtl/dram_train_sequencer.sv
module dram_train_sequencer
  import train_seq_pkg::*;
#(
  parameter int RANKS  = 4,
  parameter int REP_W  = 9,
  parameter int GAP_W  = 5,
  parameter int IDLE_W = 9,
  parameter int WAIT_W = 9,
  parameter int ITER_W = 8,
  parameter int DIR_W  = 2,
  localparam int RSEL_W = $clog2(RANKS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        iterWrEn,
  input  logic [ITER_W-1:0]           iterWrData,
  input  logic [SLOT_W-1:0]           lastSlot,
  input  logic [WAIT_W-1:0]           postWait,
  input  logic                        stopOnErr,
  input  logic                        trigEn,
  input  logic                        errIn,
  input  logic [NUM_SLOTS*3-1:0]      slotCmd,
  input  logic [NUM_SLOTS*RANKS-1:0]  slotCke,
  input  logic [NUM_SLOTS*RANKS-1:0]  slotOdt,
  input  logic [NUM_SLOTS*RANKS-1:0]  slotCsCtl,
  input  logic [NUM_SLOTS-1:0]        slotCsMode,
  input  logic [NUM_SLOTS*RSEL_W-1:0] slotRank,
  input  logic [NUM_SLOTS*DIR_W-1:0]  slotDir,
  input  logic [NUM_SLOTS*REP_W-1:0]  slotReps,
  input  logic [NUM_SLOTS*GAP_W-1:0]  slotGap,
  input  logic [NUM_SLOTS*IDLE_W-1:0] slotIdle,
  output logic                        rasN,
  output logic                        casN,
  output logic                        weN,
  output logic [RANKS-1:0]            csN,
  output logic [RANKS-1:0]            cke,
  output logic [RANKS-1:0]            odt,
  output logic [DIR_W-1:0]            dataDir,
  output logic                        cmdValid,
  output logic [3:0]                  status,
  output logic [ITER_W-1:0]           iterLeft,
  output logic                        trigOut
);
  seqStrobe_t strobe;
  logic       doneFlag, errFlag;

  train_seq_ctrl #(
    .REP_W(REP_W), .GAP_W(GAP_W), .IDLE_W(IDLE_W),
    .WAIT_W(WAIT_W), .ITER_W(ITER_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .iterWrEn(iterWrEn), .iterWrData(iterWrData),
    .lastSlot(lastSlot), .postWait(postWait), .stopOnErr(stopOnErr),
    .trigEn(trigEn), .errIn(errIn), .slotReps(slotReps), .slotGap(slotGap),
    .slotIdle(slotIdle), .strobe(strobe), .iterLeft(iterLeft),
    .doneFlag(doneFlag), .errFlag(errFlag), .trigOut(trigOut)
  );

  train_seq_datapath #(.RANKS(RANKS), .DIR_W(DIR_W)) u_dp (
    .strobe(strobe), .slotCmd(slotCmd), .slotCke(slotCke), .slotOdt(slotOdt),
    .slotCsCtl(slotCsCtl), .slotCsMode(slotCsMode), .slotRank(slotRank),
    .slotDir(slotDir), .rasN(rasN), .casN(casN), .weN(weN), .csN(csN),
    .cke(cke), .odt(odt), .dataDir(dataDir), .cmdValid(cmdValid)
  );

  assign status = {errFlag, doneFlag, strobe.busy, !strobe.busy};
endmodule

// File: rtl/train_seq_checker.sv
module train_seq_checker #(
  parameter int RANKS  = 4,
  parameter int ITER_W = 8,
  parameter int DIR_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iterWrEn,
  input logic [ITER_W-1:0] iterWrData,
  input logic              stopOnErr,
  input logic              errIn,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [RANKS-1:0]  csN,
  input logic [DIR_W-1:0]  dataDir,
  input logic              cmdValid,
  input logic [3:0]        status,
  input logic [ITER_W-1:0] iterLeft,
  input logic              trigOut
);
  logic startNow;
  assign startNow = status[0] && iterWrEn && (iterWrData != '0);

  assert_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmdValid |-> (csN == '1 && rasN && casN && weN && dataDir == '0));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> !cmdValid);

  assert_state_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(status[1:0]));

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |-> status[0]);

  assert_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && iterWrEn && iterWrData == '0) |=> (status[0] && !status[2]));

  assert_endless_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && iterLeft == '1 && !iterWrEn && !(errIn && stopOnErr))
      |=> (iterLeft == '1));

  assert_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && errIn && stopOnErr && !iterWrEn)
      |=> (status[0] && status[3] && iterLeft == '0));

  assert_trig_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (trigOut && !startNow) |=> trigOut);
endmodule

bind dram_train_sequencer train_seq_checker #(
  .RANKS(RANKS), .ITER_W(ITER_W), .DIR_W(DIR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .iterWrEn(iterWrEn), .iterWrData(iterWrData),
  .stopOnErr(stopOnErr), .errIn(errIn), .rasN(rasN), .casN(casN), .weN(weN),
  .csN(csN), .dataDir(dataDir), .cmdValid(cmdValid), .status(status),
  .iterLeft(iterLeft), .trigOut(trigOut)
);

// File: tb/dram_train_sequencer_tb.sv
`timescale 1ns/1ps
module dram_train_sequencer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        iterWrEn = 1'b0;
  logic [7:0]  iterWrData = '0;
  logic [1:0]  lastSlot = '0;
  logic [8:0]  postWait = '0;
  logic        stopOnErr = 1'b0, trigEn = 1'b0, errIn = 1'b0;
  logic [11:0] slotCmd;
  logic [15:0] slotCke, slotOdt, slotCsCtl;
  logic [3:0]  slotCsMode;
  logic [7:0]  slotRank, slotDir;
  logic [35:0] slotReps, slotIdle;
  logic [19:0] slotGap;
  logic        rasN, casN, weN, cmdValid, trigOut;
  logic [3:0]  csN, cke, odt, status;
  logic [1:0]  dataDir;
  logic [7:0]  iterLeft;

  int cfgCmd[4], cfgCtl[4], cfgMode[4], cfgRank[4], cfgDir[4];
  int cfgReps[4], cfgGap[4], cfgIdle[4];
  int cfgLast, cfgWait;
  int expTrace[0:1023];
  int expLen;
  int nChecks = 0, nFails = 0;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      slotCmd[i*3 +: 3]   = 3'(cfgCmd[i]);
      slotCsCtl[i*4 +: 4] = 4'(cfgCtl[i]);
      slotCke[i*4 +: 4]   = 4'(i + 5);
      slotOdt[i*4 +: 4]   = 4'(i * 3);
      slotCsMode[i]       = cfgMode[i][0];
      slotRank[i*2 +: 2]  = 2'(cfgRank[i]);
      slotDir[i*2 +: 2]   = 2'(cfgDir[i]);
      slotReps[i*9 +: 9]  = 9'(cfgReps[i]);
      slotGap[i*5 +: 5]   = 5'(cfgGap[i]);
      slotIdle[i*9 +: 9]  = 9'(cfgIdle[i]);
    end
    lastSlot = 2'(cfgLast);
    postWait = 9'(cfgWait);
  end

  dram_train_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .iterWrEn(iterWrEn), .iterWrData(iterWrData),
    .lastSlot(lastSlot), .postWait(postWait), .stopOnErr(stopOnErr),
    .trigEn(trigEn), .errIn(errIn), .slotCmd(slotCmd), .slotCke(slotCke),
    .slotOdt(slotOdt), .slotCsCtl(slotCsCtl), .slotCsMode(slotCsMode),
    .slotRank(slotRank), .slotDir(slotDir), .slotReps(slotReps),
    .slotGap(slotGap), .slotIdle(slotIdle), .rasN(rasN), .casN(casN),
    .weN(weN), .csN(csN), .cke(cke), .odt(odt), .dataDir(dataDir),
    .cmdValid(cmdValid), .status(status), .iterLeft(iterLeft), .trigOut(trigOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // pin word {valid, ras, cas, we, cs[3:0], dir[1:0]} expected for slot s (-1 = deselect)
  function automatic int expPins(input int s);
    int cs;
    if (s < 0) return {1'b0, 3'b111, 4'hF, 2'b00};
    cs = cfgCtl[s];
    if (cfgMode[s] != 0) cs = cs & ~(1 << cfgRank[s]);
    return {1'b1, cfgCmd[s][0], cfgCmd[s][1], cfgCmd[s][2], 4'(cs), 2'(cfgDir[s])};
  endfunction

  function automatic void buildTrace(input int iters);
    expLen = 0;
    for (int it = 0; it < iters; it++) begin
      for (int s = 0; s <= cfgLast; s++) begin
        for (int r = 0; r <= cfgReps[s]; r++) begin
          expTrace[expLen++] = s;
          if (r < cfgReps[s])
            for (int g = 0; g < cfgGap[s]; g++) expTrace[expLen++] = -1;
        end
        for (int d = 0; d < cfgIdle[s]; d++) expTrace[expLen++] = -1;
      end
      if (it < iters - 1)
        for (int w = 0; w < cfgWait; w++) expTrace[expLen++] = -1;
    end
  endfunction

  function automatic int actPins();
    return {cmdValid, rasN, casN, weN, csN, dataDir};
  endfunction

  task automatic startRun(input int cnt);
    @(negedge clk);
    iterWrEn = 1'b1;
    iterWrData = 8'(cnt);
    @(posedge clk);
    #1 iterWrEn = 1'b0;
  endtask

  // R1 R2 R3 R4 R7 R8 R9: cycle-exact trace comparison; R5 R12 at the end
  task automatic runSeq(input int iters, input string tag);
    buildTrace(iters);
    startRun(iters);
    for (int k = 0; k < expLen; k++) begin
      @(negedge clk);
      chk(actPins() == expPins(expTrace[k]), tag, actPins(), expPins(expTrace[k]));
      chk(status[1:0] == 2'b10, "R12 busy", status, 2);
    end
    @(negedge clk);
    chk(status == 4'b0101, "R5 done idle", status, 5);
    chk(iterLeft == 8'd0, "R5 count zero", iterLeft, 0);
    chk(actPins() == expPins(-1), "R9 idle deselect", actPins(), expPins(-1));
  endtask

  task automatic randCfg();
    for (int i = 0; i < 4; i++) begin
      cfgCmd[i]  = int'($urandom_range(0, 7));
      cfgCtl[i]  = int'($urandom_range(0, 15));
      cfgMode[i] = int'($urandom_range(0, 1));
      cfgRank[i] = int'($urandom_range(0, 3));
      cfgDir[i]  = int'($urandom_range(0, 3));
      cfgReps[i] = int'($urandom_range(0, 3));
      cfgGap[i]  = int'($urandom_range(0, 3));
      cfgIdle[i] = int'($urandom_range(0, 3));
    end
    cfgLast = int'($urandom_range(0, 3));
    cfgWait = int'($urandom_range(0, 3));
  endtask

  initial begin
    #(4 * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    randCfg();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(status == 4'b0001, "R12 reset status", status, 1);
    chk(actPins() == expPins(-1), "R9 reset deselect", actPins(), expPins(-1));
    chk(trigOut == 1'b0, "R11 reset trig", trigOut, 0);

    // R2: repetition count 0 issues once, back to back over all slots
    for (int i = 0; i < 4; i++) begin
      cfgCmd[i] = i; cfgCtl[i] = 4'hA; cfgMode[i] = 0; cfgRank[i] = 0;
      cfgDir[i] = i; cfgReps[i] = 0; cfgGap[i] = 3; cfgIdle[i] = 0;
    end
    cfgLast = 3; cfgWait = 2;
    runSeq(1, "R2 single issue");

    // R8: masking mode on each rank
    for (int r = 0; r < 4; r++) begin
      cfgMode[0] = 1; cfgRank[0] = r; cfgCtl[0] = 4'hF; cfgLast = 0; cfgReps[0] = 1;
      runSeq(1, "R8 cs mask");
    end

    // R3 R4: random structure
    for (int n = 0; n < 25; n++) begin
      randCfg();
      runSeq(int'($urandom_range(1, 3)), "R3 R4 R7 random trace");
    end

    // R10: error ignored without stop-on-error
    randCfg();
    stopOnErr = 1'b0; trigEn = 1'b0; errIn = 1'b1;
    runSeq(2, "R10 error ignored");
    errIn = 1'b0;
    chk(trigOut == 1'b0, "R11 trig disabled", trigOut, 0);

    // R10 R11: halt on error
    for (int i = 0; i < 4; i++) begin cfgReps[i] = 5; cfgGap[i] = 1; end
    cfgLast = 3;
    stopOnErr = 1'b1; trigEn = 1'b1;
    startRun(2);
    repeat (3) @(negedge clk);
    errIn = 1'b1;
    @(posedge clk);
    #1 errIn = 1'b0;
    @(negedge clk);
    chk(status == 4'b1001, "R10 halted status", status, 9);
    chk(iterLeft == 8'd0, "R10 count cleared", iterLeft, 0);
    chk(cmdValid == 1'b0, "R10 halted quiet", cmdValid, 0);
    chk(trigOut == 1'b1, "R11 trig set", trigOut, 1);
    repeat (3) @(negedge clk);
    chk(trigOut == 1'b1, "R11 trig sticky", trigOut, 1);
    startRun(1);
    @(negedge clk);
    chk(status == 4'b0010, "R12 start clears error", status, 2);
    chk(trigOut == 1'b0, "R11 start clears trig", trigOut, 0);
    @(negedge clk);
    iterWrEn = 1'b1; iterWrData = 8'd0;
    @(posedge clk);
    #1 iterWrEn = 1'b0;
    stopOnErr = 1'b0; trigEn = 1'b0;

    // R6: endless mode, then abort
    randCfg();
    startRun(255);
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      chk(status[1] == 1'b1 && iterLeft == 8'hFF, "R6 endless", {status, iterLeft}, 12'h2FF);
    end
    iterWrEn = 1'b1; iterWrData = 8'd0;
    @(posedge clk);
    #1 iterWrEn = 1'b0;
    @(negedge clk);
    chk(status == 4'b0001, "R6 abort idle no done", status, 1);
    chk(actPins() == expPins(-1), "R9 after abort", actPins(), expPins(-1));

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule